// File: doc/BRIEF.md
# Two-Wire Register-File Slave

This block is the serial control port of a small peripheral. It watches the two lines of an I2C bus, answers to one 7-bit device address, and keeps a bank of byte-wide control registers. The master selects the block by sending the device address. A write carries a register index and then any number of data bytes. A read returns bytes starting at the current index. All register contents are presented in parallel on one flat output bus for the rest of the chip to use.

Both bus lines are oversampled by the system clock. That clock must be at least about twenty times the bus bit rate, so an 8 MHz clock or faster suits standard and fast mode. Each line passes through a synchronizer and a stability filter before any edge is decoded. The block never stretches the clock. It only pulls SDA low, through an open-drain enable, and the pad logic outside the block turns that enable into the actual drive.

Top module: `i2c_regfile_slave`

## Requirements
- R1: A falling SDA while SCL is high is a START and makes the block expect an address byte, including in the middle of a transfer (repeated START). A rising SDA while SCL is high is a STOP and returns the block to idle. Bytes clocked after a STOP and before the next START are not acknowledged.
- R2: The block accepts the address byte when its upper seven bits, sent MSB first, equal {ADDR_PREFIX, dev_sel}, with ADDR_PREFIX defaulting to 6'b100100. Bit 0 of the byte is the direction, 0 for write and 1 for read. On a match the block pulls SDA low (sda_oe = 1) through the ninth clock.
- R3: After an address that does not match, sda_oe stays 0 and no register changes until the next START.
- R4: In a write, the byte after the address loads the register pointer from its low five bits and is acknowledged.
- R5: Each further write byte is stored at the pointer and acknowledged, and the pointer then advances by one. Register i appears on regs_flat[8*i+7:8*i].
- R6: The pointer wraps from 31 to 0, so a burst that runs past the last register overwrites registers from index 0. Reads wrap the same way.
- R7: In a read, the block drives the register at the pointer MSB first, one bit per SCL low phase. The pointer advances once for each byte loaded. A later read that sends no index continues from the advanced pointer.
- R8: When the master answers a read byte with NACK (SDA high in the ninth clock), the block releases SDA and drives nothing more until the next START.
- R9: After reset every register is 0x00, the pointer is 0 and sda_oe is 0.
- R10: A pulse on SDA shorter than FILT_LEN system clocks while SCL is high is ignored. It produces no START or STOP and leaves the byte being received unchanged.
- R11: sda_oe changes only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| dev_sel | input | 1 | Strap that sets the lowest device-address bit |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| regs_flat | output | 8*NUM_REGS | All register bytes, register i in bits 8*i+7 to 8*i |

## Verification
A bit counter that drifts by one clock shows up at the ports within one byte. The acknowledge then lands in the wrong slot, or read data comes out shifted by one bit, and the bench catches this on the next sample of the ninth clock or the next read byte. A wrong pointer shows as a byte stored at a neighbouring index on regs_flat, or as the wrong value returned on a read. Bursts that cross index 31 expose a pointer that fails to wrap within two bytes. A state machine left active after a NACK or a non-matching address would drive SDA during the next clocked byte, where the bench expects the line to read high.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ADDR  = 3'd1,
      ST_REG   = 3'd2,
      ST_WDATA = 3'd3,
      ST_RDATA = 3'd4
   } rf_state_e;
endpackage

// File: rtl/i2c_rf_deglitch.sv
module i2c_rf_deglitch #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [SYNC_STAGES-1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
   end

   generate
      if (FILT_LEN < 2) begin : g_bypass
         assign dout = sync_q[SYNC_STAGES-1];
      end else begin : g_filter
         logic [FILT_LEN-1:0] hist_q;
         logic                level_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hist_q  <= '1;
               level_q <= 1'b1;
            end else begin
               hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
               if (&hist_q)       level_q <= 1'b1;
               else if (~|hist_q) level_q <= 1'b0;
            end
         end
         assign dout = level_q;
      end
   endgenerate
endmodule

// File: rtl/i2c_rf_bus_events.sv
module i2c_rf_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic sda_f,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_evt,
   output logic stop_evt
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_f;
         sda_q <= sda_f;
      end
   end

   assign scl_rise  = scl_f & ~scl_q;
   assign scl_fall  = ~scl_f & scl_q;
   assign start_evt = scl_f & scl_q & sda_q & ~sda_f;
   assign stop_evt  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/i2c_rf_regbank.sv
module i2c_rf_regbank #(
   parameter int NUM_REGS = 32,
   parameter int PTR_W    = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [PTR_W-1:0]      wr_addr,
   input  logic [7:0]            wr_data,
   input  logic [PTR_W-1:0]      rd_addr,
   output logic [7:0]            rd_data,
   output logic [8*NUM_REGS-1:0] regs_flat
);
   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
         logic [7:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                q <= '0;
            else if (wr_en && wr_addr == PTR_W'(i))    q <= wr_data;
         end
         assign regs_flat[8*i +: 8] = q;
      end
   endgenerate

   assign rd_data = regs_flat[8*rd_addr +: 8];
endmodule

// File: rtl/i2c_rf_fsm.sv
module i2c_rf_fsm
   import i2c_rf_pkg::*;
#(
   parameter logic [5:0] ADDR_PREFIX = 6'b100100,
   parameter int         PTR_W       = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             sda_f,
   input  logic             start_evt,
   input  logic             stop_evt,
   input  logic             dev_sel,
   input  logic [7:0]       rd_data,
   output rf_state_e        state,
   output logic [PTR_W-1:0] ptr,
   output logic             wr_en,
   output logic [7:0]       wr_data,
   output logic             sda_oe
);
   logic [3:0] cnt_q;
   logic [7:0] shreg_q;
   logic [7:0] tx_q;
   logic       rd_mode_q;
   logic       nack_q;
   logic       byte_end;
   logic       ack_end;

   assign byte_end = scl_fall && (cnt_q == 4'd8);
   assign ack_end  = scl_fall && (cnt_q == 4'd9);
   assign wr_en    = !start_evt && !stop_evt && (state == ST_WDATA) && byte_end;
   assign wr_data  = shreg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         ptr       <= '0;
         cnt_q     <= '0;
         shreg_q   <= '0;
         tx_q      <= '0;
         rd_mode_q <= 1'b0;
         nack_q    <= 1'b0;
         sda_oe    <= 1'b0;
      end else if (stop_evt) begin
         state  <= ST_IDLE;
         cnt_q  <= '0;
         sda_oe <= 1'b0;
      end else if (start_evt) begin
         state     <= ST_ADDR;
         cnt_q     <= '0;
         rd_mode_q <= 1'b0;
         sda_oe    <= 1'b0;
      end else if (state != ST_IDLE) begin
         if (scl_rise) begin
            if (cnt_q < 4'd8) shreg_q <= {shreg_q[6:0], sda_f};
            else              nack_q  <= sda_f;
            cnt_q <= cnt_q + 4'd1;
         end
         if (byte_end) begin
            unique case (state)
               ST_ADDR: begin
                  if (shreg_q[7:1] == {ADDR_PREFIX, dev_sel}) begin
                     sda_oe    <= 1'b1;
                     rd_mode_q <= shreg_q[0];
                  end else begin
                     state <= ST_IDLE;
                  end
               end
               ST_REG: begin
                  sda_oe <= 1'b1;
                  ptr    <= shreg_q[PTR_W-1:0];
               end
               ST_WDATA: begin
                  sda_oe <= 1'b1;
                  ptr    <= ptr + 1'b1;
               end
               default: sda_oe <= 1'b0;
            endcase
         end else if (ack_end) begin
            cnt_q <= '0;
            unique case (state)
               ST_ADDR: begin
                  if (rd_mode_q) begin
                     state  <= ST_RDATA;
                     tx_q   <= rd_data;
                     sda_oe <= ~rd_data[7];
                     ptr    <= ptr + 1'b1;
                  end else begin
                     state  <= ST_REG;
                     sda_oe <= 1'b0;
                  end
               end
               ST_REG: begin
                  state  <= ST_WDATA;
                  sda_oe <= 1'b0;
               end
               ST_RDATA: begin
                  if (nack_q) begin
                     state  <= ST_IDLE;
                     sda_oe <= 1'b0;
                  end else begin
                     tx_q   <= rd_data;
                     sda_oe <= ~rd_data[7];
                     ptr    <= ptr + 1'b1;
                  end
               end
               default: sda_oe <= 1'b0;
            endcase
         end else if (scl_fall && state == ST_RDATA && cnt_q != 4'd0) begin
            sda_oe <= ~tx_q[6];
            tx_q   <= {tx_q[6:0], 1'b0};
         end
      end
   end
endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave
   import i2c_rf_pkg::*;
#(
   parameter logic [5:0] ADDR_PREFIX = 6'b100100,
   parameter int         NUM_REGS    = 32,
   parameter int         SYNC_STAGES = 2,
   parameter int         FILT_LEN    = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_i,
   input  logic                  sda_i,
   input  logic                  dev_sel,
   output logic                  sda_oe,
   output logic [8*NUM_REGS-1:0] regs_flat
);
   localparam int PTR_W = $clog2(NUM_REGS);

   generate
      if (NUM_REGS < 2 || NUM_REGS > 64 || (NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_bad_regs
         $error("NUM_REGS must be a power of two from 2 to 64");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (FILT_LEN < 0) begin : g_bad_filt
         $error("FILT_LEN must not be negative");
      end
   endgenerate

   logic             scl_f, sda_f;
   logic             scl_rise, scl_fall, start_evt, stop_evt;
   rf_state_e        state;
   logic [PTR_W-1:0] ptr;
   logic             wr_en;
   logic [7:0]       wr_data, rd_data;

   i2c_rf_deglitch #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_scl_flt (
      .clk(clk), .rst_n(rst_n), .din(scl_i), .dout(scl_f));

   i2c_rf_deglitch #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sda_flt (
      .clk(clk), .rst_n(rst_n), .din(sda_i), .dout(sda_f));

   i2c_rf_bus_events u_events (
      .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_evt(start_evt), .stop_evt(stop_evt));

   i2c_rf_fsm #(.ADDR_PREFIX(ADDR_PREFIX), .PTR_W(PTR_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .sda_f(sda_f), .start_evt(start_evt), .stop_evt(stop_evt),
      .dev_sel(dev_sel), .rd_data(rd_data), .state(state), .ptr(ptr),
      .wr_en(wr_en), .wr_data(wr_data), .sda_oe(sda_oe));

   i2c_rf_regbank #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(ptr),
      .wr_data(wr_data), .rd_addr(ptr), .rd_data(rd_data),
      .regs_flat(regs_flat));
endmodule

// File: rtl/i2c_rf_checker.sv
module i2c_rf_checker
   import i2c_rf_pkg::*;
#(
   parameter int NUM_REGS = 32,
   parameter int PTR_W    = 5
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  scl_f,
   input logic                  start_evt,
   input logic                  stop_evt,
   input rf_state_e             state,
   input logic                  sda_oe,
   input logic                  wr_en,
   input logic [PTR_W-1:0]      ptr,
   input logic [8*NUM_REGS-1:0] regs_flat
);
   p_start_to_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
      start_evt |=> state == ST_ADDR);

   p_stop_to_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> state == ST_IDLE);

   p_idle_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_IDLE |-> !sda_oe);

   p_regs_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(regs_flat));

   p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ptr == $past(ptr) + 1'b1);

   p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sda_oe != $past(sda_oe) |-> !scl_f);
endmodule

bind i2c_regfile_slave i2c_rf_checker #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .start_evt(start_evt),
   .stop_evt(stop_evt), .state(state), .sda_oe(sda_oe), .wr_en(wr_en),
   .ptr(ptr), .regs_flat(regs_flat));

// File: tb/sim_i2c_regfile_slave.sv
module sim_i2c_regfile_slave;
   localparam int NREG = 32;
   localparam int Q    = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            scl_m = 1'b1;
   logic            sda_m = 1'b1;
   logic            dev_sel = 1'b1;
   logic            sda_oe;
   logic [8*NREG-1:0] regs_flat;
   logic            sda_line;
   int              n_chk = 0;
   int              n_fail = 0;
   bit              done = 1'b0;

   assign sda_line = sda_m & ~sda_oe;

   always #2 clk = ~clk;

   i2c_regfile_slave u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .dev_sel(dev_sel), .sda_oe(sda_oe), .regs_flat(regs_flat));

   // {register index, data}
   localparam logic [15:0] VECS [6] = '{
      16'h00_A5, 16'h07_3C, 16'h0A_FF, 16'h13_01, 16'h1C_80, 16'h1F_5A };

   task automatic check(string req, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic wq(int n = 1);
      repeat (n * Q) @(negedge clk);
   endtask

   function automatic logic [7:0] reg_at(int idx);
      return regs_flat[8*idx +: 8];
   endfunction

   task automatic bus_start();
      sda_m = 1'b1; wq();
      scl_m = 1'b1; wq();
      sda_m = 1'b0; wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq();
      scl_m = 1'b1; wq();
      sda_m = 1'b1; wq();
   endtask

   task automatic put_bit(logic b, bit glitch = 1'b0);
      sda_m = b; wq();
      scl_m = 1'b1;
      if (glitch) begin
         wq();
         @(negedge clk) sda_m = ~b;
         @(negedge clk) sda_m = b;
         repeat (Q - 2) @(negedge clk);
      end else begin
         wq(2);
      end
      scl_m = 1'b0; wq();
   endtask

   task automatic get_bit(output logic b);
      logic late;
      sda_m = 1'b1; wq();
      scl_m = 1'b1; wq();
      b = sda_line;
      wq();
      late = sda_line;
      // R11: data seen by the master holds through the high phase
      check("R11 sda stable while scl high", late, b);
      scl_m = 1'b0; wq();
   endtask

   task automatic send_byte(logic [7:0] d, output bit ack, input int glitch_bit = -1);
      logic b;
      for (int i = 7; i >= 0; i--) put_bit(d[i], glitch_bit == i);
      get_bit(b);
      ack = !b;
   endtask

   task automatic recv_byte(output logic [7:0] d, input bit ack);
      for (int i = 7; i >= 0; i--) get_bit(d[i]);
      put_bit(!ack);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      bit         ack;
      logic [7:0] rd;
      logic       b;

      repeat (5) @(negedge clk);
      // R9: reset state
      check("R9 regs after reset", 32'(regs_flat != '0), 32'd0);
      check("R9 sda_oe after reset", 32'(sda_oe), 32'd0);
      rst_n = 1'b1;
      wq(2);

      // table walk: single-byte write, then indexed read-back
      for (int v = 0; v < 6; v++) begin
         logic [7:0] idx, dat;
         idx = VECS[v][15:8];
         dat = VECS[v][7:0];
         bus_start();
         send_byte(8'h92, ack); check("R2 address ack", 32'(ack), 32'd1);
         send_byte(idx, ack);   check("R4 index ack", 32'(ack), 32'd1);
         send_byte(dat, ack);   check("R5 data ack", 32'(ack), 32'd1);
         bus_stop();
         check("R5 register value", 32'(reg_at(int'(idx))), 32'(dat));
         bus_start();
         send_byte(8'h92, ack);
         send_byte(idx, ack);
         bus_start();  // R1 repeated START
         send_byte(8'h93, ack); check("R1 R2 read address ack", 32'(ack), 32'd1);
         recv_byte(rd, 1'b0);
         bus_stop();
         check("R7 read data", 32'(rd), 32'(dat));
      end

      // R3: wrong address (strap selects 0x92 family), no ack, no write
      bus_start();
      send_byte(8'h90, ack); check("R3 mismatch no ack", 32'(ack), 32'd0);
      send_byte(8'h00, ack); check("R3 later byte no ack", 32'(ack), 32'd0);
      send_byte(8'h77, ack); check("R3 later byte no ack", 32'(ack), 32'd0);
      bus_stop();
      check("R3 register untouched", 32'(reg_at(0)), 32'hA5);

      // R2: strap low moves the address to 0x90
      dev_sel = 1'b0;
      bus_start();
      send_byte(8'h90, ack); check("R2 strap low ack", 32'(ack), 32'd1);
      send_byte(8'h05, ack);
      send_byte(8'hC3, ack);
      bus_stop();
      check("R2 R4 write with strap low", 32'(reg_at(5)), 32'hC3);
      dev_sel = 1'b1;

      // R1: byte clocked after STOP without START is ignored
      send_byte(8'h92, ack); check("R1 no ack without START", 32'(ack), 32'd0);
      bus_stop();

      // R6: burst crossing the top index wraps and overwrites index 0
      bus_start();
      send_byte(8'h92, ack);
      send_byte(8'h1E, ack);
      send_byte(8'h11, ack);
      send_byte(8'h22, ack);
      send_byte(8'h33, ack); check("R6 wrap byte ack", 32'(ack), 32'd1);
      bus_stop();
      check("R6 index 30", 32'(reg_at(30)), 32'h11);
      check("R6 index 31", 32'(reg_at(31)), 32'h22);
      check("R6 index 0 overwritten", 32'(reg_at(0)), 32'h33);
      check("R6 index 1 untouched", 32'(reg_at(1)), 32'h00);

      // R7/R6/R8: read burst from 30 wraps, NACK releases the line
      bus_start();
      send_byte(8'h92, ack);
      send_byte(8'h1E, ack);
      bus_start();
      send_byte(8'h93, ack);
      recv_byte(rd, 1'b1); check("R7 burst byte 30", 32'(rd), 32'h11);
      recv_byte(rd, 1'b1); check("R7 burst byte 31", 32'(rd), 32'h22);
      recv_byte(rd, 1'b0); check("R6 read wraps to 0", 32'(rd), 32'h33);
      get_bit(b);          check("R8 released after NACK", 32'(b), 32'd1);
      get_bit(b);          check("R8 released after NACK", 32'(b), 32'd1);
      bus_stop();

      // R7: pointer left at 1 by the burst, read without index
      bus_start();
      send_byte(8'h93, ack);
      recv_byte(rd, 1'b0); check("R7 read continues at pointer", 32'(rd), 32'h00);
      bus_stop();
      bus_start();
      send_byte(8'h93, ack);
      recv_byte(rd, 1'b0); check("R7 pointer advanced", 32'(rd), 32'h00);
      bus_stop();

      // R10: short SDA pulse while SCL high within a data byte
      bus_start();
      send_byte(8'h92, ack);
      send_byte(8'h09, ack);
      send_byte(8'h6B, ack, 4); check("R10 glitch byte ack", 32'(ack), 32'd1);
      send_byte(8'h94, ack, 2); check("R10 transfer survives", 32'(ack), 32'd1);
      bus_stop();
      check("R10 glitch ignored index 9", 32'(reg_at(9)), 32'h6B);
      check("R10 glitch ignored index 10", 32'(reg_at(10)), 32'h94);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule